// File: doc/BRIEF.md
# Beam Position Capture Registers

This block sits beside a video timing generator. It takes a snapshot of the live 9-bit dot counter (horizontal) and line counter (vertical) and holds that snapshot in two capture registers. The CPU then reads the snapshot through byte-wide read ports. Two events trigger a snapshot:

- a CPU read of a dedicated capture-trigger address;
- a write to a programmable output port that takes the port's bit 7 from 1 to 0.

Each 9-bit held value needs two reads to fetch. A small two-state sequencer per axis (states `HALF_LO`, `HALF_HI`) picks which half the next read returns. The unused upper bits of the high half come from the open-bus byte supplied by the system. A read of the status address sends both sequencers back to `HALF_LO`.

Each sequencer has three transitions:

- `TOGGLE`: a read of its own address moves `HALF_LO` to `HALF_HI`, or `HALF_HI` to `HALF_LO`.
- `CLEAR`: a status read moves either state to `HALF_LO`.
- `HOLD`: in any other cycle the state is unchanged.

Register offsets are parameters. The defaults are:

| Offset | Register |
|---|---|
| 0x0 | capture trigger |
| 0x1 | horizontal position |
| 0x2 | vertical position |
| 0x3 | status |
| 0x8 | output port |

Read data is combinational: `rd_data` is valid in the same cycle as `cpu_rd`. All state changes at the next clock edge.

Top module: `beam_latch_regs`

## Requirements
- R1: After reset, `held_h`, `held_v`, the output-port register and both half sequencers are 0 (`HALF_LO`).
- R2: A read at the trigger address copies `h_cnt` and `v_cnt` into `held_h` and `held_v` at the next clock edge. The data returned by that read equals `open_bus`.
- R3: A write at the port address stores `cpu_wdata` into the port register. It triggers a capture only when the stored port bit 7 is 1 and `cpu_wdata[7]` is 0. Every other port write leaves the held values unchanged.
- R4: A position read while its sequencer is `HALF_LO` returns the held value's bits 7:0.
- R5: A position read while its sequencer is `HALF_HI` returns the held value's bit 8 in bit 0, with `open_bus[7:1]` in bits 7:1.
- R6: Each read of a position address toggles only that axis's sequencer. The horizontal and vertical sequencers are independent.
- R7: A status read forces both sequencers to `HALF_LO` (the `CLEAR` transition) and returns `open_bus`.
- R8: A capture leaves both sequencers unchanged. A capture between the two half reads replaces the held value, so the second read sees the new value.
- R9: A read of any other address returns `open_bus`. `rd_data` is 0 while `cpu_rd` is low. Writes to addresses other than the port change nothing.
- R10: `held_h` and `held_v` change only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| h_cnt | input | 9 | live horizontal dot counter |
| v_cnt | input | 9 | live vertical line counter |
| cpu_addr | input | 4 | register offset |
| cpu_rd | input | 1 | read strobe, one cycle per access |
| cpu_wr | input | 1 | write strobe, one cycle per access |
| cpu_wdata | input | 8 | write data |
| open_bus | input | 8 | value the bus floats to |
| rd_data | output | 8 | read data, same cycle as `cpu_rd` |
| held_h | output | 9 | captured horizontal position |
| held_v | output | 9 | captured vertical position |

## Verification
The bench builds the block with the default 9-bit counters and the default offsets. With 9-bit counters, bit 8 of the held values is reachable, so the high-half read and its open-bus merge can be checked. Directed sequences cover both capture triggers, including every combination of old and new port bit 7, plus captures that land between two half reads. A seeded random stretch then mixes reads, writes, status clears and unmapped addresses against a behavioural model.

// File: rtl/beam_latch_pkg.sv
package beam_latch_pkg;
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/beam_trig_detect.sv
module beam_trig_detect #(
    parameter int DW         = 8,
    parameter int AW         = 4,
    parameter logic [AW-1:0] TRIG_ADDR = 4'h0,
    parameter logic [AW-1:0] PORT_ADDR = 4'h8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          capture
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] port_q;
    logic          port_wr;
    logic          sw_hit;
    logic          port_fall;

    assign port_wr   = cpu_wr && (cpu_addr == PORT_ADDR);
    assign sw_hit    = cpu_rd && (cpu_addr == TRIG_ADDR);
    assign port_fall = port_wr && port_q[MSB] && !cpu_wdata[MSB];
    assign capture   = sw_hit || port_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else if (port_wr) begin
            port_q <= cpu_wdata;
        end
    end

    // R3
    port_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> port_q == $past(cpu_wdata));

    // R3
    port_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(port_q));
endmodule

// File: rtl/beam_half_seq.sv
module beam_half_seq
    import beam_latch_pkg::*;
#(
    parameter int AW = 4,
    parameter logic [AW-1:0] OWN_ADDR = 4'h1,
    parameter logic [AW-1:0] CLR_ADDR = 4'h3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rd,
    output half_e         sel
);
    half_e state_q;
    half_e state_d;
    logic  own_rd;
    logic  clr_rd;

    assign own_rd = cpu_rd && (cpu_addr == OWN_ADDR);
    assign clr_rd = cpu_rd && (cpu_addr == CLR_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HALF_LO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HALF_LO: begin
                if (clr_rd) begin
                    state_d = HALF_LO;
                end else if (own_rd) begin
                    state_d = HALF_HI;
                end
            end
            HALF_HI: begin
                if (clr_rd || own_rd) begin
                    state_d = HALF_LO;
                end
            end
            default: state_d = HALF_LO;
        endcase
    end

    assign sel = state_q;

    // R7
    clear_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd |=> sel == HALF_LO);

    // R6
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_rd && !clr_rd) |=> sel != $past(sel));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_rd && !clr_rd) |=> $stable(sel));
endmodule

// File: rtl/beam_hold_reg.sv
module beam_hold_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] live,
    output logic [W-1:0] held
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= live;
        end
    end

    assign held = held_q;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> held == $past(live));

    // R10
    no_load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));
endmodule

// File: rtl/beam_latch_regs.sv
module beam_latch_regs
    import beam_latch_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter logic [AW-1:0] TRIG_ADDR = 4'h0,
    parameter logic [AW-1:0] HPOS_ADDR = 4'h1,
    parameter logic [AW-1:0] VPOS_ADDR = 4'h2,
    parameter logic [AW-1:0] STAT_ADDR = 4'h3,
    parameter logic [AW-1:0] PORT_ADDR = 4'h8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic [DW-1:0]    open_bus,
    output logic [DW-1:0]    rd_data,
    output logic [CNT_W-1:0] held_h,
    output logic [CNT_W-1:0] held_v
);
    localparam int HI_BITS = CNT_W - DW;
    localparam int NAX     = 2;

    logic capture;
    half_e sel [NAX];
    logic [CNT_W-1:0] live_c [NAX];
    logic [CNT_W-1:0] held_c [NAX];
    logic [DW-1:0]    half_c [NAX];

    assign live_c[0] = h_cnt;
    assign live_c[1] = v_cnt;

    beam_trig_detect #(
        .DW(DW), .AW(AW), .TRIG_ADDR(TRIG_ADDR), .PORT_ADDR(PORT_ADDR)
    ) u_trig (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .capture(capture)
    );

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        localparam logic [AW-1:0] OWN = (a == 0) ? HPOS_ADDR : VPOS_ADDR;

        beam_hold_reg #(.W(CNT_W)) u_hold (
            .clk(clk), .rst_n(rst_n), .load(capture),
            .live(live_c[a]), .held(held_c[a])
        );

        beam_half_seq #(.AW(AW), .OWN_ADDR(OWN), .CLR_ADDR(STAT_ADDR)) u_seq (
            .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
            .cpu_rd(cpu_rd), .sel(sel[a])
        );

        always_comb begin
            if (sel[a] == HALF_HI) begin
                half_c[a] = {open_bus[DW-1:HI_BITS], held_c[a][CNT_W-1:DW]};
            end else begin
                half_c[a] = held_c[a][DW-1:0];
            end
        end
    end

    assign held_h = held_c[0];
    assign held_v = held_c[1];

    always_comb begin
        rd_data = '0;
        if (cpu_rd) begin
            if (cpu_addr == HPOS_ADDR) begin
                rd_data = half_c[0];
            end else if (cpu_addr == VPOS_ADDR) begin
                rd_data = half_c[1];
            end else begin
                rd_data = open_bus;
            end
        end
    end

    // R2
    trig_read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == TRIG_ADDR) |-> rd_data == open_bus);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> rd_data == '0);

    // R3
    port_fall_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == PORT_ADDR && !cpu_wdata[DW-1] &&
         !(cpu_rd && cpu_addr == TRIG_ADDR) && $past(cpu_wr && cpu_addr == PORT_ADDR
         && cpu_wdata[DW-1])) |=> held_h == $past(h_cnt));
endmodule

// File: tb/beam_latch_regs_tb.sv
module beam_latch_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] h_cnt = '0, v_cnt = '0;
    logic [3:0] cpu_addr = '0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0, open_bus = '0;
    logic [7:0] rd_data;
    logic [8:0] held_h, held_v;

    int total = 0;
    int bad = 0;

    int m_h = 0, m_v = 0, m_sh = 0, m_sv = 0, m_port = 0;

    always #10 clk = ~clk;

    beam_latch_regs u_dut (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .open_bus(open_bus), .rd_data(rd_data),
        .held_h(held_h), .held_v(held_v)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rd();
        int ob = open_bus;
        if (!cpu_rd) return 0;
        case (cpu_addr)
            4'h1: return m_sh ? ((ob & 8'hFE) | (m_h >> 8)) : (m_h & 8'hFF);
            4'h2: return m_sv ? ((ob & 8'hFE) | (m_v >> 8)) : (m_v & 8'hFF);
            default: return ob;
        endcase
    endfunction

    task automatic step(input string tag, input bit rd, input bit wr,
                        input int addr, input int wd, input int ob,
                        input int h, input int v);
        bit cap;
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = addr[3:0];
        cpu_wdata = wd[7:0]; open_bus = ob[7:0];
        h_cnt = h[8:0]; v_cnt = v[8:0];
        #2;
        chk(tag, rd_data, exp_rd());
        cap = (rd && addr == 0) || (wr && addr == 8 && m_port[7] && !wd[7]);
        @(posedge clk);
        #1;
        if (cap) begin m_h = h & 9'h1FF; m_v = v & 9'h1FF; end
        if (wr && addr == 8) m_port = wd & 8'hFF;
        if (rd && addr == 3) begin m_sh = 0; m_sv = 0; end
        else begin
            if (rd && addr == 1) m_sh ^= 1;
            if (rd && addr == 2) m_sv ^= 1;
        end
        chk({tag, " R10 held_h"}, held_h, m_h);
        chk({tag, " R10 held_v"}, held_v, m_v);
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 held_h", held_h, 0);
        chk("R1 held_v", held_v, 0);
        @(negedge clk); rst_n = 1'b1;
        // R1: first half read is low, port reg 0 means 0->0 write no capture
        step("R1 h lo", 1, 0, 1, 0, 8'hAA, 9'h155, 9'h0AA);
        step("R1 port", 0, 1, 8, 0, 0, 9'h1FF, 9'h1FF);
        step("R1 h hi", 1, 0, 1, 0, 8'hAA, 0, 0);
        // R2 software trigger
        step("R2 trig", 1, 0, 0, 0, 8'h5C, 9'h1A3, 9'h10F);
        step("R4 h lo", 1, 0, 1, 0, 8'h00, 0, 0);
        step("R5 h hi", 1, 0, 1, 0, 8'hFF, 0, 0);
        step("R4 v lo", 1, 0, 2, 0, 8'h00, 0, 0);
        // R6: H read does not move V
        step("R6 h lo", 1, 0, 1, 0, 8'h3C, 0, 0);
        step("R6 v hi", 1, 0, 2, 0, 8'h80, 0, 0);
        step("R6 h hi", 1, 0, 1, 0, 8'h81, 0, 0);
        // R7 status clears
        step("R7 h lo", 1, 0, 1, 0, 8'h00, 0, 0);
        step("R7 stat", 1, 0, 3, 0, 8'h99, 0, 0);
        step("R7 h lo2", 1, 0, 1, 0, 8'h00, 0, 0);
        step("R7 v lo", 1, 0, 2, 0, 8'h00, 0, 0);
        step("R7 stat2", 1, 0, 3, 0, 8'h11, 0, 0);
        // R3 port edges
        step("R3 0x7F", 0, 1, 8, 8'h7F, 0, 9'h111, 9'h122);
        step("R3 0x80", 0, 1, 8, 8'h80, 0, 9'h133, 9'h144);
        step("R3 fall", 0, 1, 8, 8'h00, 0, 9'h1EE, 9'h0DD);
        step("R3 lo->lo", 0, 1, 8, 8'h00, 0, 9'h001, 9'h002);
        step("R3 FF", 0, 1, 8, 8'hFF, 0, 9'h003, 9'h004);
        step("R3 hi->hi", 0, 1, 8, 8'hC0, 0, 9'h005, 9'h006);
        step("R3 fall2", 0, 1, 8, 8'h7F, 0, 9'h0F7, 9'h17E);
        // R8 capture between halves
        step("R8 h lo", 1, 0, 1, 0, 0, 0, 0);
        step("R8 trig", 1, 0, 0, 0, 8'h42, 9'h1C8, 9'h033);
        step("R8 h hi", 1, 0, 1, 0, 8'h00, 0, 0);
        // R9 unmapped and stray writes
        step("R9 rd 5", 1, 0, 5, 0, 8'h6B, 0, 0);
        step("R9 wr 1", 0, 1, 1, 8'h00, 0, 9'h0AB, 9'h0CD);
        step("R9 wr 0", 0, 1, 0, 8'h00, 0, 9'h0AB, 9'h0CD);
        step("R9 idle", 0, 0, 9, 0, 8'hFF, 9'h0AB, 9'h0CD);
        for (int i = 0; i < 3000; i++) begin
            int a;
            int r;
            r = $urandom_range(0, 3);
            a = ($urandom_range(0, 3) == 0) ? 8 : $urandom_range(0, 9);
            step("R6 R8 random", r != 0, r == 0 || r == 3, a,
                 $urandom_range(0, 255), $urandom_range(0, 255),
                 $urandom_range(0, 511), $urandom_range(0, 511));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule